// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block watches the command bus of a single-rank SDR SDRAM and checks the command stream. It decodes the command present at each rising clock edge, keeps the open or closed state of each of the four banks, and runs a set of per-bank down-counters that measure the clocks since the last activate, precharge and write. When a command breaks an ordering or minimum-spacing rule, the block sets the matching bit of a sticky error vector and records which rule was broken first. It also counts refresh commands over a fixed window of clocks and flags a window that held too few of them.

The monitor drives nothing onto the bus. All spacing limits are parameters in clocks. The burst length is taken from the mode-register-set commands it observes, so it can judge when bursts, write recovery and auto-precharge end. A synchronous clear input empties the error vector, which lets one simulation or one board session check many traffic segments in turn.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, 110 burst stop, 111 no operation. A command is ignored when cs_n is high, or when cke was low on the previous clock. Directly after reset, the previous cke counts as high.
- R2: A mode register set while any bank is open sets error bit 0. A refresh while any bank is open sets bit 1.
- R3: Any command other than no-operation fewer than T_MRD clocks after a mode register set sets bit 2.
- R4: An activate fewer than T_RC clocks after the previous activate of the same bank sets bit 3.
- R5: An activate fewer than T_RRD clocks after an activate of a different bank sets bit 4.
- R6: A read or write fewer than T_RCD clocks after the activate of its bank sets bit 5.
- R7: A precharge of an open bank fewer than T_RAS clocks after its activate sets bit 6. A precharge fewer than T_WR clocks after the last write data of that bank sets bit 7. The last write data falls burst-length minus one clocks after the write.
- R8: An activate fewer than T_RP clocks after a precharge of that bank sets bit 8. After a read with auto-precharge (addr[10] high), the precharge starts burst-length clocks after the read. After a write with auto-precharge, it starts T_WR clocks after the last data.
- R9: A precharge with addr[10] high closes all four banks, whatever ba holds. With addr[10] low, it closes only the bank selected by ba.
- R10: A read or write to a closed bank sets bit 9. An activate opens its bank, and a read or write with auto-precharge closes it.
- R11: A read or write issued fewer than burst-length clocks after a read or write with auto-precharge sets bit 10. The burst length comes from addr[2:0] of the last mode register set: 0→1, 1→2, 2→4, 3→8, 7→full page (2^COL_W), anything else→1. It is 1 after reset.
- R12: Clocks after reset are split into windows of REF_WIN clocks. A window that ends with fewer than REF_MIN refresh commands sets bit 11.
- R13: Error bits are sticky, err_flag is high while any bit is set, and clr clears the vector on the next edge, taking priority over a new error in that cycle. When the vector leaves zero, err_code takes the lowest set bit index plus one and holds until cleared; err_code is 0 while the vector is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge samples the command |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the error vector and code |
| cs_n | input | 1 | Observed chip select, active low |
| ras_n | input | 1 | Observed row strobe |
| cas_n | input | 1 | Observed column strobe |
| we_n | input | 1 | Observed write enable |
| cke | input | 1 | Observed clock enable |
| ba | input | BA_W | Observed bank address |
| addr | input | ADDR_W | Observed address bus |
| err_flag | output | 1 | High while any error bit is set |
| err_vec | output | 12 | Sticky error bits, one per rule |
| err_code | output | 4 | First error index plus one, 0 when clear |

## Verification
The hardest states to reach are the timer windows that overlap. Two examples are an activate that meets tRP but still breaks tRC, and an activate that is early only because an auto-precharge was pushed back by a long burst. To reach them, the stimulus first programs burst length 4 or 8 through a mode register set. It then places the second command exactly one clock before and exactly at the computed boundary, in two runs separated by a reset. The bench overrides tRC above tRAS plus tRP so that a tRC violation can be produced with no tRP violation beside it.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

   typedef enum logic [2:0] {
      CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
   } sd_cmd_e;

   localparam int NERR       = 12;
   localparam int E_MRS_OPEN = 0;
   localparam int E_REF_OPEN = 1;
   localparam int E_MRD      = 2;
   localparam int E_RC       = 3;
   localparam int E_RRD      = 4;
   localparam int E_RCD      = 5;
   localparam int E_RAS      = 6;
   localparam int E_WR       = 7;
   localparam int E_RP       = 8;
   localparam int E_CLOSED   = 9;
   localparam int E_AP_BUSY  = 10;
   localparam int E_REF_LOW  = 11;

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
   import sdmon_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cs_n,
   input  logic    ras_n,
   input  logic    cas_n,
   input  logic    we_n,
   input  logic    cke,
   output sd_cmd_e cmd
);

   logic cke_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_prev <= 1'b1;
      else        cke_prev <= cke;
   end

   always_comb begin
      cmd = CMD_NOP;
      if (!cs_n && cke_prev) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdmon_downcnt.sv
module sdmon_downcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         busy
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank #(
   parameter int CW    = 12,
   parameter int T_RC  = 9,
   parameter int T_RRD = 2,
   parameter int T_RCD = 3,
   parameter int T_RAS = 6,
   parameter int T_RP  = 3,
   parameter int T_WR  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act,
   input  logic          pre,
   input  logic          rd,
   input  logic          wr,
   input  logic          ap,
   input  logic [CW-1:0] bl,
   output logic          is_open,
   output logic          rc_busy,
   output logic          rrd_busy,
   output logic          rcd_busy,
   output logic          ras_busy,
   output logic          rp_busy,
   output logic          wr_busy
);

   logic          rd_ap, wr_ap, rp_load;
   logic [CW-1:0] rp_val, wr_val;

   assign rd_ap   = rd && ap;
   assign wr_ap   = wr && ap;
   assign rp_load = pre || rd_ap || wr_ap;
   assign wr_val  = bl + CW'(T_WR) - CW'(2);

   always_comb begin
      if (pre)        rp_val = CW'(T_RP - 1);
      else if (rd_ap) rp_val = bl + CW'(T_RP - 1);
      else            rp_val = bl + CW'(T_WR + T_RP - 2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 is_open <= 1'b0;
      else if (act)               is_open <= 1'b1;
      else if (pre || rd_ap || wr_ap) is_open <= 1'b0;
   end

   sdmon_downcnt #(.W(CW)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act),
                                  .val(CW'(T_RC - 1)),  .busy(rc_busy));
   sdmon_downcnt #(.W(CW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(act),
                                  .val(CW'(T_RRD - 1)), .busy(rrd_busy));
   sdmon_downcnt #(.W(CW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act),
                                  .val(CW'(T_RCD - 1)), .busy(rcd_busy));
   sdmon_downcnt #(.W(CW)) u_ras (.clk(clk), .rst_n(rst_n), .load(act),
                                  .val(CW'(T_RAS - 1)), .busy(ras_busy));
   sdmon_downcnt #(.W(CW)) u_rp  (.clk(clk), .rst_n(rst_n), .load(rp_load),
                                  .val(rp_val),         .busy(rp_busy));
   sdmon_downcnt #(.W(CW)) u_wr  (.clk(clk), .rst_n(rst_n), .load(wr),
                                  .val(wr_val),         .busy(wr_busy));

endmodule

// File: rtl/sdmon_refwin.sv
module sdmon_refwin #(
   parameter int WIN    = 8512000,
   parameter int MINREF = 8192
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_hit,
   output logic short_win
);

   localparam int WW = (WIN > 2) ? $clog2(WIN) : 1;
   localparam int RW = $clog2(MINREF + 1);

   logic [WW-1:0] win_cnt;
   logic [RW-1:0] ref_cnt, ref_next;

   assign ref_next = (ref_hit && (ref_cnt != RW'(MINREF))) ? ref_cnt + RW'(1) : ref_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt   <= '0;
         ref_cnt   <= '0;
         short_win <= 1'b0;
      end else if (win_cnt == WW'(WIN - 1)) begin
         short_win <= (ref_next < RW'(MINREF));
         win_cnt   <= '0;
         ref_cnt   <= '0;
      end else begin
         short_win <= 1'b0;
         win_cnt   <= win_cnt + WW'(1);
         ref_cnt   <= ref_next;
      end
   end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdmon_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int BA_W      = 2,
   parameter int AP_BIT    = 10,
   parameter int COL_W     = 10,
   parameter int T_RC      = 9,
   parameter int T_RRD     = 2,
   parameter int T_RCD     = 3,
   parameter int T_RAS     = 6,
   parameter int T_RP      = 3,
   parameter int T_WR      = 2,
   parameter int T_MRD     = 2,
   parameter int REF_MIN   = 8192,
   parameter int REF_WIN   = 8512000,
   parameter bit REF_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              cke,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic              err_flag,
   output logic [NERR-1:0]   err_vec,
   output logic [$clog2(NERR+1)-1:0] err_code
);

   localparam int NBANK     = 1 << BA_W;
   localparam int FULL_PAGE = 1 << COL_W;
   localparam int CW        = $clog2(FULL_PAGE + T_RC + T_RAS + T_WR + T_RP + T_MRD + 2);
   localparam int CDW       = $clog2(NERR + 1);
   localparam logic [ADDR_W-1:0] USED_MASK = ADDR_W'((1 << AP_BIT) | 7);

   // elaboration-time parameter checks
   if (AP_BIT >= ADDR_W || AP_BIT < 3) begin : g_bad_ap
      $error("auto-precharge bit must lie inside the address bus above the burst field");
   end
   if (COL_W > AP_BIT) begin : g_bad_col
      $error("column field must sit below the auto-precharge bit");
   end
   if (T_RC < 1 || T_RRD < 1 || T_RCD < 1 || T_RAS < 1 || T_RP < 1 || T_WR < 1 || T_MRD < 1) begin : g_bad_t
      $error("timing limits must be at least one clock");
   end
   if (T_RAS > T_RC) begin : g_bad_ras
      $error("row active time cannot exceed row cycle time");
   end
   if (REF_MIN < 1 || REF_WIN < 2) begin : g_bad_ref
      $error("refresh window parameters out of range");
   end

   sd_cmd_e          cmd;
   logic             ap, addr_unused;
   logic [CW-1:0]    bl_q;
   logic             mrd_busy, ap_busy, ref_short, any_open, is_rdwr;
   logic [NBANK-1:0] act_b, pre_b, rd_b, wr_b, open_v;
   logic [NBANK-1:0] rc_v, rrd_v, rcd_v, ras_v, rp_v, wr_v;
   logic [NERR-1:0]  e_now, err_q;
   logic [CDW-1:0]   code_q;

   assign ap          = addr[AP_BIT];
   assign addr_unused = ^(addr & ~USED_MASK);
   assign is_rdwr     = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign any_open    = |open_v;

   sdmon_decode u_dec (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .cke(cke), .cmd(cmd)
   );

   // burst length captured from mode register set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bl_q <= CW'(1);
      else if (cmd == CMD_MRS) begin
         unique case (addr[2:0])
            3'd1:    bl_q <= CW'(2);
            3'd2:    bl_q <= CW'(4);
            3'd3:    bl_q <= CW'(8);
            3'd7:    bl_q <= CW'(FULL_PAGE);
            default: bl_q <= CW'(1);
         endcase
      end
   end

   sdmon_downcnt #(.W(CW)) u_mrd (
      .clk(clk), .rst_n(rst_n), .load(cmd == CMD_MRS),
      .val(CW'(T_MRD - 1)), .busy(mrd_busy)
   );

   sdmon_downcnt #(.W(CW)) u_apb (
      .clk(clk), .rst_n(rst_n), .load(is_rdwr && ap),
      .val(bl_q - CW'(1)), .busy(ap_busy)
   );

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic sel;
      assign sel      = (ba == BA_W'(g));
      assign act_b[g] = (cmd == CMD_ACT) && sel;
      assign pre_b[g] = (cmd == CMD_PRE) && (ap || sel);
      assign rd_b[g]  = (cmd == CMD_RD) && sel;
      assign wr_b[g]  = (cmd == CMD_WR) && sel;

      sdmon_bank #(
         .CW(CW), .T_RC(T_RC), .T_RRD(T_RRD), .T_RCD(T_RCD),
         .T_RAS(T_RAS), .T_RP(T_RP), .T_WR(T_WR)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .act(act_b[g]), .pre(pre_b[g]),
         .rd(rd_b[g]), .wr(wr_b[g]), .ap(ap), .bl(bl_q),
         .is_open(open_v[g]), .rc_busy(rc_v[g]), .rrd_busy(rrd_v[g]),
         .rcd_busy(rcd_v[g]), .ras_busy(ras_v[g]), .rp_busy(rp_v[g]),
         .wr_busy(wr_v[g])
      );
   end

   if (REF_CHECK) begin : g_ref
      sdmon_refwin #(.WIN(REF_WIN), .MINREF(REF_MIN)) u_refwin (
         .clk(clk), .rst_n(rst_n), .ref_hit(cmd == CMD_REF), .short_win(ref_short)
      );
   end else begin : g_noref
      assign ref_short = 1'b0;
   end

   always_comb begin
      e_now              = '0;
      e_now[E_MRS_OPEN]  = (cmd == CMD_MRS) && any_open;
      e_now[E_REF_OPEN]  = (cmd == CMD_REF) && any_open;
      e_now[E_MRD]       = (cmd != CMD_NOP) && mrd_busy;
      e_now[E_RC]        = |(act_b & rc_v);
      e_now[E_RRD]       = (cmd == CMD_ACT) && |(rrd_v & ~act_b);
      e_now[E_RCD]       = |((rd_b | wr_b) & rcd_v);
      e_now[E_RAS]       = |(pre_b & open_v & ras_v);
      e_now[E_WR]        = |(pre_b & wr_v);
      e_now[E_RP]        = |(act_b & rp_v);
      e_now[E_CLOSED]    = |((rd_b | wr_b) & ~open_v);
      e_now[E_AP_BUSY]   = is_rdwr && ap_busy;
      e_now[E_REF_LOW]   = ref_short;
   end

   function automatic logic [CDW-1:0] first_code(input logic [NERR-1:0] v);
      first_code = '0;
      for (int i = NERR - 1; i >= 0; i--) begin
         if (v[i]) first_code = CDW'(i + 1);
      end
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= '0;
         code_q <= '0;
      end else if (clr) begin
         err_q  <= '0;
         code_q <= '0;
      end else begin
         err_q <= err_q | e_now;
         if (err_q == '0 && e_now != '0) code_q <= first_code(e_now);
      end
   end

   assign err_vec  = err_q;
   assign err_code = code_q;
   assign err_flag = |err_q;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
   import sdmon_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int BA_W  = 2,
   parameter int CDW   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             cs_n,
   input logic             ap,
   input logic [BA_W-1:0]  ba,
   input sd_cmd_e          cmd,
   input logic [NBANK-1:0] bank_open,
   input logic [NERR-1:0]  err_vec,
   input logic [CDW-1:0]   err_code
);

   localparam logic [NERR-1:0] NOREF = ~(NERR'(1) << E_REF_LOW);

   // R1: a deselected cycle adds no command error
   assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !clr) |=> ((err_vec & NOREF) == ($past(err_vec) & NOREF)));

   // R2: mode register set with an open bank
   assert_mrs_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MRS && (|bank_open) && !clr) |=> err_vec[E_MRS_OPEN]);

   // R9: precharge-all closes every bank
   assert_pall_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE && ap) |=> (bank_open == '0));

   // R10: access to a closed bank
   assert_closed_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == CMD_RD || cmd == CMD_WR) && !bank_open[ba] && !clr) |=> err_vec[E_CLOSED]);

   // R13: sticky bits, clear, code consistency
   assert_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((err_vec & $past(err_vec)) == $past(err_vec)));

   assert_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (err_vec == '0));

   assert_code_match_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_code != '0) == (err_vec != '0)));

   assert_code_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_vec != '0) && !clr) |=> $stable(err_code));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
   .NBANK(NBANK), .BA_W(BA_W), .CDW(CDW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .ap(ap), .ba(ba),
   .cmd(cmd), .bank_open(open_v), .err_vec(err_vec), .err_code(err_code)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

   localparam [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                    C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;
   localparam [12:0] A10 = 13'h400;

   logic        clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
   logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic        err_flag;
   logic [11:0] err_vec;
   logic [3:0]  err_code;

   int checks = 0, fails = 0;

   always #2.5ns clk = ~clk;

   sdram_cmd_monitor #(
      .T_RC(10), .REF_MIN(2), .REF_WIN(300)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
      .err_flag(err_flag), .err_vec(err_vec), .err_code(err_code)
   );

   task automatic drive(input [2:0] c, input [1:0] b, input [12:0] a,
                        input logic csn, input logic ck);
      {ras_n, cas_n, we_n} = c; ba = b; addr = a; cs_n = csn; cke = ck;
      @(negedge clk);
      {ras_n, cas_n, we_n} = C_NOP; ba = '0; addr = '0; cs_n = 1'b0; cke = 1'b1;
   endtask

   task automatic cmd(input [2:0] c, input [1:0] b, input [12:0] a);
      drive(c, b, a, 1'b0, 1'b1);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic clear_st();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic check_vec(input string tag, input logic [11:0] exp);
      checks++;
      if (err_vec !== exp) begin
         fails++;
         $display("FAIL %s err_vec=%h expected %h", tag, err_vec, exp);
      end
   endtask

   task automatic check_code(input string tag, input logic [3:0] exp, input logic fexp);
      checks++;
      if (err_code !== exp || err_flag !== fexp) begin
         fails++;
         $display("FAIL %s err_code=%0d err_flag=%b expected %0d/%b",
                  tag, err_code, err_flag, exp, fexp);
      end
   endtask

   task automatic t_reset();
      do_reset();
      check_vec("R13 reset vector", 12'h000);
      check_code("R13 reset code", 4'd0, 1'b0);
   endtask

   task automatic t_inhibit();
      do_reset();
      drive(C_RD, 2'd0, 13'h0, 1'b1, 1'b1);
      check_vec("R1 deselected read ignored", 12'h000);
      drive(C_NOP, 2'd0, 13'h0, 1'b0, 1'b0);
      drive(C_RD, 2'd0, 13'h0, 1'b0, 1'b1);
      check_vec("R1 read after cke low ignored", 12'h000);
      cmd(C_RD, 2'd0, 13'h0);
      check_vec("R10 read closed bank", 12'h200);
   endtask

   task automatic t_open();
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0);
      idle(8);
      cmd(C_MRS, 2'd0, 13'h0);
      check_vec("R2 mrs with open bank", 12'h001);
      clear_st();
      check_vec("R13 clear", 12'h000);
      cmd(C_REF, 2'd0, 13'h0);
      check_vec("R2 refresh with open bank", 12'h002);
   endtask

   task automatic t_mrd();
      do_reset();
      cmd(C_MRS, 2'd0, 13'h0);
      cmd(C_ACT, 2'd0, 13'h0);
      check_vec("R3 command one clock after mrs", 12'h004);
      do_reset();
      cmd(C_MRS, 2'd0, 13'h0);
      idle(1);
      cmd(C_ACT, 2'd0, 13'h0);
      check_vec("R3 command two clocks after mrs", 12'h000);
   endtask

   task automatic t_rc();
      do_reset();
      cmd(C_ACT, 2'd1, 13'h0); idle(5);
      cmd(C_PRE, 2'd1, 13'h0); idle(2);
      cmd(C_ACT, 2'd1, 13'h0);
      check_vec("R4 activate at 9 of 10", 12'h008);
      do_reset();
      cmd(C_ACT, 2'd1, 13'h0); idle(5);
      cmd(C_PRE, 2'd1, 13'h0); idle(3);
      cmd(C_ACT, 2'd1, 13'h0);
      check_vec("R4 activate at 10", 12'h000);
   endtask

   task automatic t_rrd();
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0);
      cmd(C_ACT, 2'd1, 13'h0);
      check_vec("R5 other bank one clock", 12'h010);
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0); idle(1);
      cmd(C_ACT, 2'd1, 13'h0);
      check_vec("R5 other bank two clocks", 12'h000);
   endtask

   task automatic t_rcd();
      do_reset();
      cmd(C_ACT, 2'd2, 13'h0); idle(1);
      cmd(C_RD, 2'd2, 13'h0);
      check_vec("R6 read at 2", 12'h020);
      do_reset();
      cmd(C_ACT, 2'd2, 13'h0); idle(2);
      cmd(C_WR, 2'd2, 13'h0);
      check_vec("R6 write at 3", 12'h000);
   endtask

   task automatic t_ras_wr();
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0); idle(4);
      cmd(C_PRE, 2'd0, 13'h0);
      check_vec("R7 precharge at 5 of tRAS 6", 12'h040);
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0); idle(4);
      cmd(C_WR, 2'd0, 13'h0);
      cmd(C_PRE, 2'd0, 13'h0);
      check_vec("R7 precharge one clock after write", 12'h080);
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0); idle(4);
      cmd(C_WR, 2'd0, 13'h0); idle(1);
      cmd(C_PRE, 2'd0, 13'h0);
      check_vec("R7 precharge two clocks after write", 12'h000);
      do_reset();
      cmd(C_MRS, 2'd0, 13'd2); idle(1);
      cmd(C_ACT, 2'd0, 13'h0); idle(4);
      cmd(C_WR, 2'd0, 13'h0); idle(3);
      cmd(C_PRE, 2'd0, 13'h0);
      check_vec("R7 burst 4 precharge early", 12'h080);
      do_reset();
      cmd(C_MRS, 2'd0, 13'd2); idle(1);
      cmd(C_ACT, 2'd0, 13'h0); idle(4);
      cmd(C_WR, 2'd0, 13'h0); idle(4);
      cmd(C_PRE, 2'd0, 13'h0);
      check_vec("R7 burst 4 precharge on time", 12'h000);
   endtask

   task automatic t_rp();
      do_reset();
      cmd(C_PRE, 2'd3, 13'h0); idle(1);
      cmd(C_ACT, 2'd3, 13'h0);
      check_vec("R8 activate 2 after precharge", 12'h100);
      do_reset();
      cmd(C_PRE, 2'd3, 13'h0); idle(2);
      cmd(C_ACT, 2'd3, 13'h0);
      check_vec("R8 activate 3 after precharge", 12'h000);
      do_reset();
      cmd(C_MRS, 2'd0, 13'd3); idle(1);
      cmd(C_ACT, 2'd0, 13'h0); idle(2);
      cmd(C_RD, 2'd0, A10); idle(9);
      cmd(C_ACT, 2'd0, 13'h0);
      check_vec("R8 burst 8 auto precharge early", 12'h100);
      do_reset();
      cmd(C_MRS, 2'd0, 13'd3); idle(1);
      cmd(C_ACT, 2'd0, 13'h0); idle(2);
      cmd(C_RD, 2'd0, A10); idle(10);
      cmd(C_ACT, 2'd0, 13'h0);
      check_vec("R8 burst 8 auto precharge on time", 12'h000);
   endtask

   task automatic t_pall();
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0); idle(1);
      cmd(C_ACT, 2'd2, 13'h0); idle(7);
      cmd(C_PRE, 2'd1, A10);
      check_vec("R9 precharge all", 12'h000);
      cmd(C_RD, 2'd0, 13'h0);
      check_vec("R9 bank 0 closed by precharge all", 12'h200);
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0); idle(5);
      cmd(C_PRE, 2'd1, 13'h0);
      cmd(C_RD, 2'd0, 13'h0);
      check_vec("R9 single precharge keeps bank 0 open", 12'h000);
   endtask

   task automatic t_closed();
      do_reset();
      cmd(C_WR, 2'd3, 13'h0);
      check_vec("R10 write closed bank", 12'h200);
      check_code("R10 code", 4'd10, 1'b1);
   endtask

   task automatic t_ap();
      do_reset();
      cmd(C_MRS, 2'd0, 13'd2); idle(1);
      cmd(C_ACT, 2'd0, 13'h0); idle(1);
      cmd(C_ACT, 2'd1, 13'h0);
      cmd(C_RD, 2'd0, A10); idle(1);
      cmd(C_RD, 2'd1, 13'h0);
      check_vec("R11 read during auto precharge burst", 12'h400);
      do_reset();
      cmd(C_MRS, 2'd0, 13'd2); idle(1);
      cmd(C_ACT, 2'd0, 13'h0); idle(1);
      cmd(C_ACT, 2'd1, 13'h0);
      cmd(C_RD, 2'd0, A10); idle(3);
      cmd(C_RD, 2'd1, 13'h0);
      check_vec("R11 read after burst end", 12'h000);
   endtask

   task automatic t_ref();
      do_reset();
      cmd(C_REF, 2'd0, 13'h0);
      cmd(C_REF, 2'd0, 13'h0);
      idle(305);
      check_vec("R12 full window", 12'h000);
      cmd(C_REF, 2'd0, 13'h0);
      idle(300);
      check_vec("R12 short window", 12'h800);
      check_code("R12 code", 4'd12, 1'b1);
   endtask

   task automatic t_sticky();
      do_reset();
      cmd(C_ACT, 2'd0, 13'h0);
      cmd(C_ACT, 2'd1, 13'h0);
      check_code("R13 first code", 4'd5, 1'b1);
      idle(2);
      cmd(C_RD, 2'd2, 13'h0);
      check_vec("R13 sticky accumulate", 12'h210);
      check_code("R13 code held", 4'd5, 1'b1);
      clear_st();
      check_vec("R13 cleared vector", 12'h000);
      check_code("R13 cleared code", 4'd0, 1'b0);
      do_reset();
      cmd(C_MRS, 2'd0, 13'h0);
      cmd(C_RD, 2'd3, 13'h0);
      check_vec("R13 simultaneous errors", 12'h204);
      check_code("R13 lowest index wins", 4'd3, 1'b1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_inhibit();
      t_open();
      t_mrd();
      t_rc();
      t_rrd();
      t_rcd();
      t_ras_wr();
      t_rp();
      t_pall();
      t_closed();
      t_ap();
      t_ref();
      t_sticky();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #500us;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule